// File: doc/BRIEF.md
# DDR2 Write-Burst Command Timing Checker

This block watches a decoded DDR2 command stream, one command and one bank address per clock, and judges every command against the spacing rules that follow a write burst. Write latency is taken as CAS latency minus one, with no additive latency, so a burst's last data beat lands WL + BL/2 clocks after its WRITE. Recovery windows (write-to-read and write-to-precharge) are counted from that point. The write-to-read term is never shorter than two clocks. The tWTR and tWR parameters are whole clock counts, already rounded up.

For each command type the block publishes a per-bank "may issue now" vector. A controller can use it to gate its scheduler, and a bench can use it as a reference model. Any command that breaks a rule sets a sticky violation flag. A 3-bit cause code records the first broken rule until a synchronous clear. A write to a bank with auto precharge adds delays that apply to the other banks.

Top module: `ddr2_wr_timing_chk`

## Requirements
- R1: Command codes are NOP=0, WRITE=1, WRITE-AP=2, READ=3, READ-AP=4, PRECHARGE=5, ACTIVATE=6. After reset the flag is low, the cause code is 0, and every may-issue vector is all ones.
- R2: A WRITE or WRITE-AP issued exactly BL/2 clocks after the previous WRITE is legal, which gives gapless data. During the clocks between the two, may_write is all zeros.
- R3: With BL=4, any non-NOP command issued 1 clock after a WRITE sets the flag with cause 1.
- R4: With BL=8, the only command allowed within 4 clocks of a plain WRITE is a WRITE or WRITE-AP at exactly 2 clocks after it. Any other command or offset in that window sets cause 2, and so does any command within 4 clocks of a WRITE-AP. A WRITE at 4 clocks is legal.
- R5: A READ or READ-AP needs at least WL + BL/2 + max(2, tWTR) clocks after the last WRITE to any bank. An earlier one sets cause 3.
- R6: A PRECHARGE to bank b needs at least WL + BL/2 + tWR clocks after the last WRITE to bank b. An earlier one sets cause 4. PRECHARGE to other banks is not held back by that write.
- R7: After a WRITE-AP to bank n, a READ or READ-AP to a bank m other than n needs at least (CL-1) + BL/2 + tWTR clocks. An earlier one sets cause 5. Cause 5 takes priority over cause 3 when both apply.
- R8: After a WRITE-AP to bank n, a PRECHARGE, ACTIVATE or WRITE to another bank is legal once BL/2 clocks have elapsed.
- R9: The flag and cause hold the first violation and ignore later ones. Asserting clr returns both to 0 on the next clock, and clr takes priority over a violation in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of flag and cause |
| cmd | input | 3 | Command code of this clock |
| bank | input | $clog2(NUM_BANKS) | Bank address of this clock |
| may_write | output | NUM_BANKS | WRITE legal now, per bank |
| may_write_ap | output | NUM_BANKS | WRITE-AP legal now, per bank |
| may_read | output | NUM_BANKS | READ legal now, per bank |
| may_read_ap | output | NUM_BANKS | READ-AP legal now, per bank |
| may_pre | output | NUM_BANKS | PRECHARGE legal now, per bank |
| may_act | output | NUM_BANKS | ACTIVATE legal now, per bank |
| viol | output | 1 | Sticky violation flag |
| viol_cause | output | 3 | Cause of first violation (0 none) |

## Verification
The hardest case to reach is a read to another bank in the short interval after a WRITE-AP. In that interval the auto-precharge delay and the write-to-read delay are both still running, and the result depends on which cause wins. The bench uses tWTR=1 so that the two delays differ by one clock. A read at one offset then gives cause 5, and a read one clock later gives cause 3. The truncation rule needs a second instance built for BL=8. On that instance, writes and reads are placed at offsets 2, 3 and 4 after both a plain WRITE and a WRITE-AP.

// File: rtl/ddr2wc_pkg.sv
`timescale 1ns/1ps
package ddr2wc_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_WR  = 3'd1,
    CMD_WRA = 3'd2,
    CMD_RD  = 3'd3,
    CMD_RDA = 3'd4,
    CMD_PRE = 3'd5,
    CMD_ACT = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    CZ_NONE   = 3'd0,
    CZ_INT4   = 3'd1,
    CZ_TRUNC8 = 3'd2,
    CZ_WTR    = 3'd3,
    CZ_TWR    = 3'd4,
    CZ_AP     = 3'd5
  } cause_e;

  function automatic logic is_write(input logic [2:0] c);
    return (c == CMD_WR) || (c == CMD_WRA);
  endfunction

  function automatic logic is_read(input logic [2:0] c);
    return (c == CMD_RD) || (c == CMD_RDA);
  endfunction
endpackage

// File: rtl/wcc_window.sv
`timescale 1ns/1ps
// Global burst window and write-to-read spacing.
module wcc_window
  import ddr2wc_pkg::*;
#(
  parameter int BL   = 4,
  parameter int CL   = 4,
  parameter int TWTR = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] cmd,
  output logic       idle_q,
  output logic       wr_ok_q,
  output logic       wtr_ok_q
);
  localparam int HALF     = BL / 2;
  localparam int WL       = CL - 1;
  localparam int WTR_EFF  = (TWTR > 2) ? TWTR : 2;
  localparam int WIN_LOAD = HALF - 1;
  localparam int WTR_LOAD = WL + HALF + WTR_EFF - 1;
  localparam int TRUNC_AT = HALF - 2;
  localparam int WCW      = $clog2(WIN_LOAD + 2);
  localparam int TCW      = $clog2(WTR_LOAD + 2);

  logic [WCW-1:0] win_q, win_d;
  logic [TCW-1:0] wtr_q, wtr_d;
  logic           wr, trunc_d, wr_ok_d;

  assign wr = is_write(cmd);

  always_comb begin
    if (wr)             win_d = WCW'(WIN_LOAD);
    else if (win_q != 0) win_d = win_q - 1'b1;
    else                win_d = '0;
    if (wr)             wtr_d = TCW'(WTR_LOAD);
    else if (wtr_q != 0) wtr_d = wtr_q - 1'b1;
    else                wtr_d = '0;
  end

  // Only a plain BL=8 write leaves a truncation slot open.
  if (BL == 8) begin : g_trunc
    logic tr_q;
    always_ff @(posedge clk) begin
      if (rst)     tr_q <= 1'b0;
      else if (wr) tr_q <= (cmd == CMD_WR);
    end
    assign trunc_d = wr ? (cmd == CMD_WR) : tr_q;
  end else begin : g_notrunc
    assign trunc_d = 1'b0;
  end

  assign wr_ok_d = (win_d == 0) || (trunc_d && (win_d == WCW'(TRUNC_AT)));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= '0;
      wtr_q    <= '0;
      idle_q   <= 1'b1;
      wr_ok_q  <= 1'b1;
      wtr_ok_q <= 1'b1;
    end else begin
      win_q    <= win_d;
      wtr_q    <= wtr_d;
      idle_q   <= (win_d == 0);
      wr_ok_q  <= wr_ok_d;
      wtr_ok_q <= (wtr_d == 0);
    end
  end

  p_window_opens_r2: assert property (@(posedge clk) disable iff (rst)
    wr |=> (!idle_q && !wr_ok_q));
  p_wtr_arms_r5: assert property (@(posedge clk) disable iff (rst)
    wr |=> !wtr_ok_q);
  p_idle_allows_write_r4: assert property (@(posedge clk) disable iff (rst)
    idle_q |-> wr_ok_q);
endmodule

// File: rtl/wcc_bank.sv
`timescale 1ns/1ps
// Per-bank write recovery and auto-precharge read delay.
module wcc_bank
  import ddr2wc_pkg::*;
#(
  parameter int BW   = 3,
  parameter int BIDX = 0,
  parameter int BL   = 4,
  parameter int CL   = 4,
  parameter int TWTR = 3,
  parameter int TWR  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cmd,
  input  logic [BW-1:0] bank,
  output logic          pre_ok_q,
  output logic          ap_ok_q
);
  localparam int HALF    = BL / 2;
  localparam int WL      = CL - 1;
  localparam int TWR_LD  = WL + HALF + TWR - 1;
  localparam int AP_LD   = (CL - 1) + HALF + TWTR - 1;
  localparam int RCW     = $clog2(TWR_LD + 2);
  localparam int ACW     = $clog2(AP_LD + 2);

  logic [RCW-1:0] twr_q, twr_d;
  logic [ACW-1:0] ap_q, ap_d;
  logic           hit;

  assign hit = (bank == BW'(BIDX));

  always_comb begin
    if (is_write(cmd) && hit) twr_d = RCW'(TWR_LD);
    else if (twr_q != 0)      twr_d = twr_q - 1'b1;
    else                      twr_d = '0;
    if ((cmd == CMD_WRA) && !hit) ap_d = ACW'(AP_LD);
    else if (ap_q != 0)           ap_d = ap_q - 1'b1;
    else                          ap_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      twr_q    <= '0;
      ap_q     <= '0;
      pre_ok_q <= 1'b1;
      ap_ok_q  <= 1'b1;
    end else begin
      twr_q    <= twr_d;
      ap_q     <= ap_d;
      pre_ok_q <= (twr_d == 0);
      ap_ok_q  <= (ap_d == 0);
    end
  end

  p_twr_arms_r6: assert property (@(posedge clk) disable iff (rst)
    (is_write(cmd) && hit) |=> !pre_ok_q);
  p_ap_arms_other_r7: assert property (@(posedge clk) disable iff (rst)
    ((cmd == CMD_WRA) && !hit) |=> !ap_ok_q);
endmodule

// File: rtl/wcc_judge.sv
`timescale 1ns/1ps
// Rule evaluation, cause priority and sticky capture.
module wcc_judge
  import ddr2wc_pkg::*;
#(
  parameter int NB = 8,
  parameter int BW = 3,
  parameter int BL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [2:0]    cmd,
  input  logic [BW-1:0] bank,
  input  logic          idle,
  input  logic          wr_ok,
  input  logic          wtr_ok,
  input  logic [NB-1:0] ap_ok,
  input  logic [NB-1:0] pre_ok,
  output logic          viol_q,
  output logic [2:0]    cause_q
);
  localparam cause_e WIN_CAUSE = (BL == 4) ? CZ_INT4 : CZ_TRUNC8;

  cause_e now;
  logic   bad_win;

  assign bad_win = (cmd != CMD_NOP) && !idle && !(is_write(cmd) && wr_ok);

  always_comb begin
    if (bad_win)                              now = WIN_CAUSE;
    else if (is_read(cmd) && !ap_ok[bank])    now = CZ_AP;
    else if (is_read(cmd) && !wtr_ok)         now = CZ_WTR;
    else if ((cmd == CMD_PRE) && !pre_ok[bank]) now = CZ_TWR;
    else                                      now = CZ_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      viol_q  <= 1'b0;
      cause_q <= CZ_NONE;
    end else if (!viol_q && (now != CZ_NONE)) begin
      viol_q  <= 1'b1;
      cause_q <= now;
    end
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (viol_q && !clr) |=> (viol_q && $stable(cause_q)));
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!viol_q && (cause_q == 3'd0)));
  p_cause_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    viol_q |-> (cause_q != 3'd0));
endmodule

// File: rtl/ddr2_wr_timing_chk.sv
`timescale 1ns/1ps
module ddr2_wr_timing_chk
  import ddr2wc_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CL        = 4,
  parameter int BL        = 4,
  parameter int TWTR      = 3,
  parameter int TWR       = 4,
  localparam int BW       = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic [2:0]           cmd,
  input  logic [BW-1:0]        bank,
  output logic [NUM_BANKS-1:0] may_write,
  output logic [NUM_BANKS-1:0] may_write_ap,
  output logic [NUM_BANKS-1:0] may_read,
  output logic [NUM_BANKS-1:0] may_read_ap,
  output logic [NUM_BANKS-1:0] may_pre,
  output logic [NUM_BANKS-1:0] may_act,
  output logic                 viol,
  output logic [2:0]           viol_cause
);
  logic                 idle, wr_ok, wtr_ok;
  logic [NUM_BANKS-1:0] ap_ok, pre_ok;

  wcc_window #(.BL(BL), .CL(CL), .TWTR(TWTR)) u_win (
    .clk(clk), .rst(rst), .cmd(cmd),
    .idle_q(idle), .wr_ok_q(wr_ok), .wtr_ok_q(wtr_ok)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    wcc_bank #(.BW(BW), .BIDX(b), .BL(BL), .CL(CL), .TWTR(TWTR), .TWR(TWR)) u_bank (
      .clk(clk), .rst(rst), .cmd(cmd), .bank(bank),
      .pre_ok_q(pre_ok[b]), .ap_ok_q(ap_ok[b])
    );
  end

  wcc_judge #(.NB(NUM_BANKS), .BW(BW), .BL(BL)) u_judge (
    .clk(clk), .rst(rst), .clr(clr), .cmd(cmd), .bank(bank),
    .idle(idle), .wr_ok(wr_ok), .wtr_ok(wtr_ok),
    .ap_ok(ap_ok), .pre_ok(pre_ok),
    .viol_q(viol), .cause_q(viol_cause)
  );

  assign may_write    = {NUM_BANKS{wr_ok}};
  assign may_write_ap = {NUM_BANKS{wr_ok}};
  assign may_read     = {NUM_BANKS{idle & wtr_ok}} & ap_ok;
  assign may_read_ap  = {NUM_BANKS{idle & wtr_ok}} & ap_ok;
  assign may_pre      = {NUM_BANKS{idle}} & pre_ok;
  assign may_act      = {NUM_BANKS{idle}};

  p_illegal_read_flagged_r5: assert property (@(posedge clk) disable iff (rst)
    (!viol && !clr && is_read(cmd) && !may_read[bank]) |=> viol);
  p_illegal_pre_flagged_r6: assert property (@(posedge clk) disable iff (rst)
    (!viol && !clr && (cmd == CMD_PRE) && !may_pre[bank]) |=> viol);
  p_legal_write_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!viol && !clr && is_write(cmd) && may_write[bank]) |=> !viol);
endmodule

// File: tb/ddr2_wr_timing_chk_test.sv
`timescale 1ns/1ps
module ddr2_wr_timing_chk_test;
  localparam int NB = 8;
  localparam logic [2:0] NOP = 3'd0, WR = 3'd1, WRA = 3'd2, RD = 3'd3,
                         RDA = 3'd4, PRE = 3'd5, ACT = 3'd6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic clr = 1'b0, clr8 = 1'b0;
  logic [2:0] cmd = NOP, cmd8 = NOP;
  logic [2:0] bank = '0, bank8 = '0;
  logic [NB-1:0] mw, mwa, mr, mra, mp, ma;
  logic [NB-1:0] mw8, mwa8, mr8, mra8, mp8, ma8;
  logic viol, viol8;
  logic [2:0] cause, cause8;

  int checks = 0;
  int fails  = 0;

  ddr2_wr_timing_chk #(.NUM_BANKS(NB), .CL(4), .BL(4), .TWTR(1), .TWR(4)) uut (
    .clk(clk), .rst(rst), .clr(clr), .cmd(cmd), .bank(bank),
    .may_write(mw), .may_write_ap(mwa), .may_read(mr), .may_read_ap(mra),
    .may_pre(mp), .may_act(ma), .viol(viol), .viol_cause(cause)
  );

  ddr2_wr_timing_chk #(.NUM_BANKS(NB), .CL(4), .BL(8), .TWTR(1), .TWR(4)) uut_b8 (
    .clk(clk), .rst(rst), .clr(clr8), .cmd(cmd8), .bank(bank8),
    .may_write(mw8), .may_write_ap(mwa8), .may_read(mr8), .may_read_ap(mra8),
    .may_pre(mp8), .may_act(ma8), .viol(viol8), .viol_cause(cause8)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [2:0] b);
    cmd = c; bank = b;
    @(posedge clk); #1;
    cmd = NOP; bank = '0;
  endtask

  task automatic nops(input int n);
    repeat (n) step(NOP, 3'd0);
  endtask

  task automatic clear_a();
    clr = 1'b1; @(posedge clk); #1; clr = 1'b0;
    nops(16);
  endtask

  task automatic step8(input logic [2:0] c, input logic [2:0] b);
    cmd8 = c; bank8 = b;
    @(posedge clk); #1;
    cmd8 = NOP; bank8 = '0;
  endtask

  task automatic nops8(input int n);
    repeat (n) step8(NOP, 3'd0);
  endtask

  task automatic clear_b();
    clr8 = 1'b1; @(posedge clk); #1; clr8 = 1'b0;
    nops8(16);
  endtask

  task automatic t_reset();
    chk("R1 viol after reset", viol, 0);
    chk("R1 cause after reset", cause, 0);
    chk("R1 may_write after reset", mw, 8'hFF);
    chk("R1 may_read after reset", mr, 8'hFF);
    chk("R1 may_pre after reset", mp, 8'hFF);
    chk("R1 may_act after reset", ma, 8'hFF);
  endtask

  task automatic t_back_to_back();
    step(WR, 3'd0);
    chk("R2 may_write closed at offset 1", mw, 8'h00);
    nops(1);
    chk("R2 may_write open at offset 2", mw, 8'hFF);
    step(WR, 3'd1);
    nops(1);
    step(WRA, 3'd2);
    chk("R2 gapless writes legal", viol, 0);
    nops(16);
  endtask

  task automatic t_interrupt4();
    step(WR, 3'd0); step(RD, 3'd3);
    chk("R3 read at offset 1 flag", viol, 1);
    chk("R3 read at offset 1 cause", cause, 1);
    clear_a();
    step(WR, 3'd0); step(WR, 3'd0);
    chk("R3 write at offset 1 cause", cause, 1);
    clear_a();
    step(WRA, 3'd2); step(ACT, 3'd5);
    chk("R3 activate at offset 1 cause", cause, 1);
    clear_a();
  endtask

  task automatic t_wtr();
    step(WR, 3'd0); nops(5);
    chk("R5 may_read low at offset 6", mr, 8'h00);
    step(RD, 3'd0);
    chk("R5 read at offset 6 cause", cause, 3);
    clear_a();
    step(WR, 3'd0); nops(6);
    chk("R5 may_read high at offset 7", mr, 8'hFF);
    chk("R5 may_read_ap high at offset 7", mra, 8'hFF);
    step(RDA, 3'd2);
    chk("R5 read-ap at offset 7 legal", viol, 0);
    nops(16);
  endtask

  task automatic t_twr();
    step(WR, 3'd2); nops(7);
    chk("R6 may_pre at offset 8", mp, 8'hFB);
    step(PRE, 3'd2);
    chk("R6 early precharge cause", cause, 4);
    clear_a();
    step(WR, 3'd2); nops(1); step(PRE, 3'd3);
    chk("R6 other-bank precharge legal", viol, 0);
    nops(6);
    chk("R6 may_pre bank2 at offset 9", mp[2], 1);
    step(PRE, 3'd2);
    chk("R6 precharge at offset 9 legal", viol, 0);
    nops(16);
  endtask

  task automatic t_ap();
    step(WRA, 3'd1); nops(4);
    chk("R7 may_read bank4 low at offset 5", mr[4], 0);
    step(RD, 3'd4);
    chk("R7 other-bank read at offset 5 cause", cause, 5);
    clear_a();
    step(WRA, 3'd1); nops(4); step(RD, 3'd1);
    chk("R7 same-bank read falls to write-to-read cause", cause, 3);
    clear_a();
    step(WRA, 3'd1); nops(5);
    chk("R7 may_read bank4 low at offset 6", mr[4], 0);
    step(RDA, 3'd4);
    chk("R7 read at offset 6 gives write-to-read cause", cause, 3);
    clear_a();
  endtask

  task automatic t_ap_other();
    step(WRA, 3'd1); nops(1);
    chk("R8 may_pre bank4 at offset 2", mp[4], 1);
    step(PRE, 3'd4); step(ACT, 3'd5); step(WR, 3'd6);
    chk("R8 pre/act/write to other banks legal", viol, 0);
    nops(16);
  endtask

  task automatic t_sticky();
    step(WR, 3'd0); step(RD, 3'd0);
    nops(1); step(RD, 3'd1);
    chk("R9 first cause kept", cause, 1);
    chk("R9 flag kept", viol, 1);
    clr = 1'b1; cmd = RD; bank = 3'd0;
    @(posedge clk); #1;
    clr = 1'b0; cmd = NOP;
    chk("R9 clear flag", viol, 0);
    chk("R9 clear cause", cause, 0);
    nops(16);
  endtask

  task automatic t_trunc8();
    step8(WR, 3'd0);
    chk("R4 bl8 may_write low at offset 1", mw8, 8'h00);
    nops8(1);
    chk("R4 bl8 may_write open at offset 2", mw8, 8'hFF);
    step8(WR, 3'd1);
    chk("R4 truncating write at offset 2 legal", viol8, 0);
    nops8(16);
    step8(WR, 3'd0); nops8(2);
    chk("R4 bl8 may_write low at offset 3", mw8, 8'h00);
    step8(WR, 3'd1);
    chk("R4 write at offset 3 cause", cause8, 2);
    clear_b();
    step8(WR, 3'd0); nops8(1); step8(RD, 3'd0);
    chk("R4 read at offset 2 cause", cause8, 2);
    clear_b();
    step8(WRA, 3'd0); nops8(1); step8(WR, 3'd1);
    chk("R4 truncating write-ap burst cause", cause8, 2);
    clear_b();
    step8(WR, 3'd0); nops8(3);
    chk("R4 bl8 may_write open at offset 4", mw8, 8'hFF);
    step8(WR, 3'd1);
    chk("R4 write at offset 4 legal", viol8, 0);
    nops8(16);
  endtask

  initial begin
    #(4 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_back_to_back();
    t_interrupt4();
    t_wtr();
    t_twr();
    t_ap();
    t_ap_other();
    t_sticky();
    t_trunc8();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule